// File: doc/BRIEF.md
# Two-Byte Handshake Output Sequencer

This block sits between a converter and an 8-bit receiver, such as a peripheral port latch or a serial transmitter's holding register. The converter delivers a 12-bit magnitude, a polarity bit and an over-range bit, with a one-cycle completion pulse. The block sends each result as two bytes over a shared bus. The high-order byte goes first and the low-order byte second. Each byte is marked by its own active-low enable and by a one-cycle active-low load strobe. The receiver latches the byte on the strobe's rising edge.

Pacing comes from the receiver's SEND level. SEND high means the receiver is ready. After a strobe, the block keeps the current byte on the bus until SEND has gone low and then high again. A rising edge on MODE requests one transfer on demand, using the most recently captured result. While MODE stays high, every completion pulse found in idle starts a new transfer. At the start of a transfer the result is copied into a holding register, so data that arrives later cannot disturb the bytes in flight.

Top module: `result_byte_sender`

## Requirements
- R1: While reset is high and in the cycle after it falls, both enables and the load strobe are high (inactive), the bus output-enable is 0 and the bus reads 0x00.
- R2: In idle, a MODE low-to-high transition starts a transfer. In the cycle after the clock edge that sees MODE high for the first time, the high-byte enable is low. If a completion pulse arrives in that same cycle, its data is the data sent.
- R3: During the high byte, the bus carries the polarity bit in bit 7, the over-range bit in bit 6, zeros in bits 5 and 4, and magnitude bits 11..8 in bits 3..0. The bus output-enable is 1 and the low-byte enable is high.
- R4: During the low byte, the bus carries magnitude bits 7..0, the low-byte enable is low and the high-byte enable is high.
- R5: The load strobe is low for exactly one cycle per byte. It goes low only in the cycle after an edge at which SEND was high, and never while SEND has stayed low since the byte was presented.
- R6: After a strobe, while SEND is low, the enabled byte and its enable stay unchanged and no further strobe occurs.
- R7: After a high-byte strobe, the low byte (with its strobe) appears one cycle after SEND is seen high again, following a low phase.
- R8: After the low byte's strobe, once SEND goes low and then high, the low-byte enable returns high and the block is idle. In idle the bus is not driven (output-enable 0, value 0x00).
- R9: With MODE held high, each completion pulse received in idle starts a transfer of that pulse's data.
- R10: In idle, no transfer starts while MODE stays high without a completion pulse. A completion pulse while MODE is low starts nothing.
- R11: A completion pulse during a transfer changes neither byte being sent.
- R12: An on-demand transfer sends the most recently captured result, including one captured during an earlier transfer or while MODE was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | Transfer request: rising edge = one transfer, held high = transfer after every conversion |
| send_i | input | 1 | Receiver ready level |
| conv_done_i | input | 1 | One-cycle pulse: conversion result valid |
| conv_sign_i | input | 1 | Polarity bit of the result |
| conv_over_i | input | 1 | Over-range bit of the result |
| conv_mag_i | input | 12 | Result magnitude |
| bus_o | output | 8 | Byte data, 0 when not driven |
| bus_oe_o | output | 1 | Bus drive enable |
| hi_en_n_o | output | 1 | High-byte enable, active low |
| lo_en_n_o | output | 1 | Low-byte enable, active low |
| load_n_o | output | 1 | Byte load strobe, active low, one cycle |

## Verification
A table of results is sent in continuous mode. The table mixes all four polarity/over-range combinations with magnitudes that have only the top bit set, only low bits set, all bits set and no bits set, so any slip or swap in the byte packing shows up. Directed cases cover the following:
- a completion pulse injected mid-transfer, which separates the holding register from the latest-result register;
- on-demand requests that must send a result captured earlier;
- MODE held high with no pulse, and a pulse with MODE low, both of which must start nothing;
- a start while SEND is low, which must delay the strobe;
- reset in the middle of a transfer.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

    localparam int MAG_W    = 12;
    localparam int BYTE_W   = 8;
    localparam int HI_MAG_W = MAG_W - BYTE_W;
    localparam int PAD_W    = BYTE_W - 2 - HI_MAG_W;

    typedef struct packed {
        logic             sign;
        logic             over;
        logic [MAG_W-1:0] mag;
    } result_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HI_ARM,
        ST_HI_STB,
        ST_HI_HOLD,
        ST_HI_REL,
        ST_LO_STB,
        ST_LO_HOLD,
        ST_LO_REL
    } seq_state_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_HI,
        SEL_LO
    } byte_sel_t;

    function automatic logic [BYTE_W-1:0] pack_hi(input result_t r);
        return {r.sign, r.over, {PAD_W{1'b0}}, r.mag[MAG_W-1:BYTE_W]};
    endfunction

    function automatic logic [BYTE_W-1:0] pack_lo(input result_t r);
        return r.mag[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/rbs_start_ctl.sv
module rbs_start_ctl (
    input  logic clk,
    input  logic rst,
    input  logic mode_i,
    input  logic conv_done_i,
    input  logic idle_i,
    output logic start_o
);
    logic mode_q;
    logic demand_req;
    logic cont_req;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= 1'b0;
        else     mode_q <= mode_i;
    end

    // on demand: first cycle MODE is seen high
    assign demand_req = mode_i & ~mode_q;
    // continuous: MODE already high, new result arrives
    assign cont_req   = mode_i & mode_q & conv_done_i;

    assign start_o = idle_i & (demand_req | cont_req);
endmodule

// File: rtl/rbs_result_store.sv
module rbs_result_store
    import rbs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    conv_done_i,
    input  result_t conv_res_i,
    input  logic    load_i,
    output result_t held_o
);
    result_t latest_q;
    result_t held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            latest_q <= '0;
            held_q   <= '0;
        end else begin
            if (conv_done_i) latest_q <= conv_res_i;
            if (load_i)      held_q   <= conv_done_i ? conv_res_i : latest_q;
        end
    end

    assign held_o = held_q;
endmodule

// File: rtl/rbs_seq_fsm.sv
module rbs_seq_fsm
    import rbs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start_i,
    input  logic      send_i,
    output logic      idle_o,
    output byte_sel_t sel_o,
    output logic      load_n_o
);
    seq_state_t state_q;
    seq_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i) state_d = ST_HI_ARM;
            ST_HI_ARM:  if (send_i)  state_d = ST_HI_STB;
            ST_HI_STB:               state_d = ST_HI_HOLD;
            ST_HI_HOLD: if (!send_i) state_d = ST_HI_REL;
            ST_HI_REL:  if (send_i)  state_d = ST_LO_STB;
            ST_LO_STB:               state_d = ST_LO_HOLD;
            ST_LO_HOLD: if (!send_i) state_d = ST_LO_REL;
            ST_LO_REL:  if (send_i)  state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_HI_ARM, ST_HI_STB, ST_HI_HOLD, ST_HI_REL: sel_o = SEL_HI;
            ST_LO_STB, ST_LO_HOLD, ST_LO_REL:            sel_o = SEL_LO;
            default:                                     sel_o = SEL_NONE;
        endcase
    end

    assign idle_o   = (state_q == ST_IDLE);
    assign load_n_o = !((state_q == ST_HI_STB) || (state_q == ST_LO_STB));
endmodule

// File: rtl/rbs_byte_drive.sv
module rbs_byte_drive
    import rbs_pkg::*;
(
    input  result_t           held_i,
    input  byte_sel_t         sel_i,
    output logic [BYTE_W-1:0] bus_o,
    output logic              bus_oe_o,
    output logic              hi_en_n_o,
    output logic              lo_en_n_o
);
    always_comb begin
        bus_o     = '0;
        bus_oe_o  = 1'b0;
        hi_en_n_o = 1'b1;
        lo_en_n_o = 1'b1;
        unique case (sel_i)
            SEL_HI: begin
                bus_o     = pack_hi(held_i);
                bus_oe_o  = 1'b1;
                hi_en_n_o = 1'b0;
            end
            SEL_LO: begin
                bus_o     = pack_lo(held_i);
                bus_oe_o  = 1'b1;
                lo_en_n_o = 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/result_byte_sender.sv
module result_byte_sender
    import rbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_i,
    input  logic              send_i,
    input  logic              conv_done_i,
    input  logic              conv_sign_i,
    input  logic              conv_over_i,
    input  logic [MAG_W-1:0]  conv_mag_i,
    output logic [BYTE_W-1:0] bus_o,
    output logic              bus_oe_o,
    output logic              hi_en_n_o,
    output logic              lo_en_n_o,
    output logic              load_n_o
);
    result_t   conv_res;
    result_t   held;
    byte_sel_t sel;
    logic      idle;
    logic      start;

    assign conv_res = '{sign: conv_sign_i, over: conv_over_i, mag: conv_mag_i};

    rbs_start_ctl u_start (
        .clk         (clk),
        .rst         (rst),
        .mode_i      (mode_i),
        .conv_done_i (conv_done_i),
        .idle_i      (idle),
        .start_o     (start)
    );

    rbs_result_store u_store (
        .clk         (clk),
        .rst         (rst),
        .conv_done_i (conv_done_i),
        .conv_res_i  (conv_res),
        .load_i      (start),
        .held_o      (held)
    );

    rbs_seq_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start),
        .send_i   (send_i),
        .idle_o   (idle),
        .sel_o    (sel),
        .load_n_o (load_n_o)
    );

    rbs_byte_drive u_drive (
        .held_i    (held),
        .sel_i     (sel),
        .bus_o     (bus_o),
        .bus_oe_o  (bus_oe_o),
        .hi_en_n_o (hi_en_n_o),
        .lo_en_n_o (lo_en_n_o)
    );
endmodule

// File: rtl/rbs_checker.sv
module rbs_checker (
    input logic       clk,
    input logic       rst,
    input logic       mode_i,
    input logic       send_i,
    input logic [7:0] bus_o,
    input logic       bus_oe_o,
    input logic       hi_en_n_o,
    input logic       lo_en_n_o,
    input logic       load_n_o
);
    AST_ENABLES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(!hi_en_n_o && !lo_en_n_o)); // R4

    AST_STROBE_NEEDS_SEND: assert property (@(posedge clk) disable iff (rst)
        !load_n_o |-> $past(send_i)); // R5

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        !load_n_o |=> load_n_o); // R5

    AST_STROBE_IN_BYTE: assert property (@(posedge clk) disable iff (rst)
        !load_n_o |-> (!hi_en_n_o || !lo_en_n_o)); // R5

    AST_BUS_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (hi_en_n_o && lo_en_n_o) |-> (!bus_oe_o && bus_o == 8'h00)); // R8

    AST_HI_BYTE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!hi_en_n_o && $past(!hi_en_n_o)) |-> $stable(bus_o)); // R11

    AST_LO_BYTE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!lo_en_n_o && $past(!lo_en_n_o)) |-> $stable(bus_o)); // R6

    AST_LO_AFTER_HI: assert property (@(posedge clk) disable iff (rst)
        $fell(lo_en_n_o) |-> ($past(!hi_en_n_o) && $past(send_i))); // R7

    AST_START_NEEDS_MODE: assert property (@(posedge clk) disable iff (rst)
        $fell(hi_en_n_o) |-> $past(mode_i)); // R2
endmodule

bind result_byte_sender rbs_checker u_rbs_checker (
    .clk       (clk),
    .rst       (rst),
    .mode_i    (mode_i),
    .send_i    (send_i),
    .bus_o     (bus_o),
    .bus_oe_o  (bus_oe_o),
    .hi_en_n_o (hi_en_n_o),
    .lo_en_n_o (lo_en_n_o),
    .load_n_o  (load_n_o)
);

// File: tb/result_byte_sender_test.sv
module result_byte_sender_test;
    logic        clk = 1'b0;
    logic        rst, mode, send, done, sign, over;
    logic [11:0] mag;
    logic [7:0]  bus;
    logic        oe, hi_n, lo_n, ld_n;
    int          checks = 0;
    int          fails  = 0;
    bit          finished = 0;

    // {sign, over, magnitude, expected high byte, expected low byte}
    localparam int NV = 6;
    localparam logic [29:0] VEC [NV] = '{
        {1'b0, 1'b0, 12'h000, 8'h00, 8'h00},
        {1'b1, 1'b0, 12'hABC, 8'h8A, 8'hBC},
        {1'b0, 1'b1, 12'hFFF, 8'h4F, 8'hFF},
        {1'b1, 1'b1, 12'h5A5, 8'hC5, 8'hA5},
        {1'b0, 1'b0, 12'h800, 8'h08, 8'h00},
        {1'b1, 1'b0, 12'h07F, 8'h80, 8'h7F}
    };

    always #5 clk = ~clk;

    result_byte_sender uut (
        .clk(clk), .rst(rst), .mode_i(mode), .send_i(send),
        .conv_done_i(done), .conv_sign_i(sign), .conv_over_i(over),
        .conv_mag_i(mag), .bus_o(bus), .bus_oe_o(oe),
        .hi_en_n_o(hi_n), .lo_en_n_o(lo_n), .load_n_o(ld_n)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_idle(input string req);
        chk(req, hi_n, 1); chk(req, lo_n, 1); chk(req, ld_n, 1);
        chk(req, oe, 0);   chk(req, bus, 8'h00);
    endtask

    task automatic put(input logic s, input logic o, input logic [11:0] m);
        sign = s; over = o; mag = m;
    endtask

    // entered with the block presenting the high byte and send high
    task automatic xfer(input logic [7:0] eh, input logic [7:0] el, input bit inject);
        chk("R3 high enable", hi_n, 0); chk("R3 low enable off", lo_n, 1);
        chk("R3 high byte", bus, eh);   chk("R3 bus driven", oe, 1);
        chk("R5 no strobe yet", ld_n, 1);
        tick;
        chk("R5 high strobe", ld_n, 0); chk("R3 high byte at strobe", bus, eh);
        tick;
        chk("R5 strobe one cycle", ld_n, 1);
        send = 0;
        tick;
        if (inject) begin
            put(1'b0, 1'b1, 12'h3C3); done = 1;   // R11 mid-transfer result
        end
        for (int k = 0; k < 3; k++) begin
            chk("R6 high held", hi_n, 0); chk("R6 high byte held", bus, eh);
            chk("R6 no strobe while send low", ld_n, 1);
            tick;
            done = 0;
        end
        send = 1;
        tick;
        chk("R7 low enable", lo_n, 0); chk("R7 high enable off", hi_n, 1);
        chk("R4 low byte", bus, el);   chk("R5 low strobe", ld_n, 0);
        tick;
        chk("R5 strobe one cycle", ld_n, 1);
        send = 0;
        tick;
        for (int k = 0; k < 2; k++) begin
            chk("R6 low held", lo_n, 0); chk("R6 low byte held", bus, el);
            chk("R6 no strobe while send low", ld_n, 1);
            tick;
        end
        send = 1;
        tick;
        chk_idle("R8 end of transfer");
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        rst = 1; mode = 0; send = 1; done = 0; put(0, 0, 12'h000);
        repeat (3) tick;
        chk_idle("R1 in reset");
        rst = 0;
        tick;
        chk_idle("R1 after reset");

        // table walk: first entry by MODE rising edge (R2), the rest continuous (R9)
        for (int i = 0; i < NV; i++) begin
            put(VEC[i][29], VEC[i][28], VEC[i][27:16]);
            done = 1;
            if (i == 0) mode = 1;
            tick;
            done = 0;
            xfer(VEC[i][15:8], VEC[i][7:0], 0);
        end

        // R10: MODE held high, no new result
        for (int k = 0; k < 5; k++) begin
            tick;
            chk_idle("R10 idle with mode high");
        end

        // R11: result arriving mid-transfer does not corrupt bytes
        put(1'b1, 1'b0, 12'h123); done = 1;
        tick;
        done = 0;
        xfer(8'h81, 8'h23, 1);

        // R12: on demand sends the result captured mid-transfer
        mode = 0; tick;
        mode = 1; tick;
        xfer(8'h43, 8'hC3, 0);

        // R10: result with MODE low starts nothing; R12 sends it on demand
        mode = 0; put(1'b1, 1'b1, 12'hFED); done = 1;
        tick;
        done = 0;
        for (int k = 0; k < 3; k++) begin
            chk_idle("R10 no start with mode low");
            tick;
        end
        mode = 1; tick;
        xfer(8'hCF, 8'hED, 0);

        // R5: start with send low delays the strobe
        mode = 0; tick;
        send = 0; mode = 1; tick;
        for (int k = 0; k < 4; k++) begin
            chk("R5 no strobe while send low", ld_n, 1);
            chk("R3 high byte waiting", bus, 8'hCF);
            tick;
        end
        send = 1; tick;
        chk("R5 strobe after send high", ld_n, 0);
        tick; send = 0; tick; send = 1; tick;
        chk("R7 low byte after send cycle", bus, 8'hED);
        chk("R5 low strobe", ld_n, 0);
        tick; send = 0; tick; send = 1; tick;
        chk_idle("R8 idle after delayed transfer");

        // R1: reset in the middle of a transfer
        mode = 0; tick;
        mode = 1; tick;
        tick; tick; send = 0; tick;
        rst = 1; tick;
        chk_idle("R1 reset mid-transfer");
        rst = 0; send = 1; mode = 0; tick;
        chk_idle("R1 idle after mid-transfer reset");

        summary();
    end
endmodule